// File: doc/BRIEF.md
# Secure key store access controller

This block guards a small store of six 56-bit key entries that is meant to persist across resets, as a battery-backed memory would. A register-style access port, standing in for a test access path, issues single-cycle read and write requests. The block runs in one of two modes: open, where every entry can be written and read back, and locked, where entries accept writes but a read never returns stored data.

The block leaves reset locked. The only way into the open mode is an unlock request, and it starts an erase sequencer. The sequencer clears the entries one per clock, stalls all port traffic while it runs, and then sends a single-cycle request to the surrounding design to wipe its configuration. A lock request taken in the open mode returns the block to locked on the next clock and leaves the stored entries as they are.

Top module: `key_store_ctrl`

## Requirements
- R1: After rst_ni is released, secure_o is 1 and busy_o, cfg_clear_o, rvalid_o, denied_o and addr_err_o are all 0.
- R2: While open (secure_o=0), a write (req_i=1, we_i=1) to an address from 0 to 5 stores wdata_i. A read (req_i=1, we_i=0) returns the entry on rdata_o, with rvalid_o=1, in the cycle after the request. A read issued the cycle after a write sees the new value.
- R3: While locked, a read of an address from 0 to 5 gives rvalid_o=1, denied_o=1 and rdata_o=0 in the cycle after the request.
- R4: A lock_i pulse while open sets secure_o from the next clock, and later reads are denied.
- R5: An unlock_i pulse while locked holds busy_o high for exactly 6 cycles starting the next clock, with secure_o=0. cfg_clear_o is high only in the first cycle after busy_o falls.
- R6: After an erase, every entry from 0 to 5 reads as zero, whatever it held before.
- R7: Requests presented while busy_o=1 produce no rvalid_o, denied_o or addr_err_o response and write nothing.
- R8: A request to address 6 or 7 in either mode gives addr_err_o=1, plus rvalid_o=1 with rdata_o=0 for a read, in the next cycle. It writes nothing.
- R9: unlock_i while open and lock_i while locked have no effect: no busy_o, no cfg_clear_o, no change of secure_o.
- R10: rvalid_o, denied_o and addr_err_o are high only in the single cycle after the request that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Entry address |
| wdata_i | input | 56 | Write data |
| lock_i | input | 1 | Request to enter locked mode |
| unlock_i | input | 1 | Request to leave locked mode (starts erase) |
| rdata_o | output | 56 | Read data, zero unless an open read of a valid address |
| rvalid_o | output | 1 | Read response valid |
| denied_o | output | 1 | Read refused because the block is locked |
| addr_err_o | output | 1 | Request addressed a nonexistent entry |
| busy_o | output | 1 | Erase in progress, port stalled |
| secure_o | output | 1 | Locked mode |
| cfg_clear_o | output | 1 | One-cycle configuration-clear request |

## Verification
A wrong mode state shows on the cycle after the next read: either denied_o appears where data was expected, or stored data leaks out where a denial was due. A miscounted or stuck erase pointer shows as the wrong number of busy_o cycles and a misplaced cfg_clear_o pulse. Any entry the erase skips comes back non-zero on the sweep read that follows, one cycle after it is addressed. A stall that leaks lets a write issued during the erase survive, and the same sweep catches it.

// File: rtl/key_store_pkg.sv
package key_store_pkg;
  typedef enum logic [1:0] {
    MODE_SECURE = 2'd0,
    MODE_ERASE  = 2'd1,
    MODE_OPEN   = 2'd2
  } kmode_e;
endpackage

// File: rtl/key_mode_fsm.sv
module key_mode_fsm
  import key_store_pkg::*;
#(
  parameter int NUM_KEYS = 6,
  parameter int ADDR_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              unlock_i,
  output logic              busy_o,
  output logic              secure_o,
  output logic              cfg_clear_o,
  output logic [ADDR_W-1:0] erase_addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_KEYS - 1);

  kmode_e            mode_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SECURE;
      ptr_q  <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      unique case (mode_q)
        MODE_SECURE: if (unlock_i) begin
          mode_q <= MODE_ERASE;
          ptr_q  <= '0;
        end
        MODE_ERASE: begin
          if (ptr_q == LAST) begin
            mode_q <= MODE_OPEN;
            clr_q  <= 1'b1;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        MODE_OPEN: if (lock_i) mode_q <= MODE_SECURE;
        default: mode_q <= MODE_SECURE;
      endcase
    end
  end

  assign busy_o       = (mode_q == MODE_ERASE);
  assign secure_o     = (mode_q == MODE_SECURE);
  assign cfg_clear_o  = clr_q;
  assign erase_addr_o = ptr_q;

  assert_clear_after_erase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> cfg_clear_o);
  assert_clear_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clear_o |=> !cfg_clear_o);
  assert_erase_from_secure_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(secure_o));
  assert_lock_needs_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(secure_o) |-> $past(lock_i));
endmodule

// File: rtl/key_array.sv
module key_array #(
  parameter int NUM_KEYS = 6,
  parameter int KEY_W    = 56,
  parameter int ADDR_W   = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [KEY_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [KEY_W-1:0]  rdata_o
);
  // No reset: contents model a store that survives reset.
  logic [KEY_W-1:0] mem_q [NUM_KEYS];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (we_i && waddr_i == ADDR_W'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (raddr_i == ADDR_W'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/key_read_gate.sv
module key_read_gate #(
  parameter int KEY_W = 56
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             rd_i,
  input  logic             addr_ok_i,
  input  logic             secure_i,
  input  logic [KEY_W-1:0] arr_rdata_i,
  output logic [KEY_W-1:0] rdata_o,
  output logic             rvalid_o,
  output logic             denied_o,
  output logic             addr_err_o
);
  logic rd_ok;
  assign rd_ok = acc_i & rd_i & addr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      denied_o   <= 1'b0;
      addr_err_o <= 1'b0;
    end else begin
      rvalid_o   <= acc_i & rd_i;
      addr_err_o <= acc_i & ~addr_ok_i;
      denied_o   <= rd_ok & secure_i;
      rdata_o    <= (rd_ok & ~secure_i) ? arr_rdata_i : '0;
    end
  end

  assert_denied_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    denied_o |-> (rdata_o == '0) && rvalid_o);
  assert_addr_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (rdata_o == '0) && !denied_o);
endmodule

// File: rtl/key_store_ctrl.sv
module key_store_ctrl #(
  parameter int NUM_KEYS = 6,
  parameter int KEY_W    = 56,
  parameter int ADDR_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  wdata_i,
  input  logic              lock_i,
  input  logic              unlock_i,
  output logic [KEY_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic              denied_o,
  output logic              addr_err_o,
  output logic              busy_o,
  output logic              secure_o,
  output logic              cfg_clear_o
);
  logic [ADDR_W-1:0] erase_addr;
  logic              acc, addr_ok, host_we, arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [KEY_W-1:0]  arr_wdata, arr_rdata;

  key_mode_fsm #(.NUM_KEYS(NUM_KEYS), .ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .lock_i, .unlock_i,
    .busy_o, .secure_o, .cfg_clear_o,
    .erase_addr_o(erase_addr)
  );

  assign acc       = req_i & ~busy_o;
  assign addr_ok   = {1'b0, addr_i} < (ADDR_W + 1)'(NUM_KEYS);
  assign host_we   = acc & we_i & addr_ok;
  assign arr_we    = busy_o | host_we;
  assign arr_waddr = busy_o ? erase_addr : addr_i;
  assign arr_wdata = busy_o ? '0 : wdata_i;

  key_array #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_arr (
    .clk_i, .we_i(arr_we), .waddr_i(arr_waddr), .wdata_i(arr_wdata),
    .raddr_i(addr_i), .rdata_o(arr_rdata)
  );

  key_read_gate #(.KEY_W(KEY_W)) u_gate (
    .clk_i, .rst_ni, .acc_i(acc), .rd_i(~we_i), .addr_ok_i(addr_ok),
    .secure_i(secure_o), .arr_rdata_i(arr_rdata),
    .rdata_o, .rvalid_o, .denied_o, .addr_err_o
  );

  assert_busy_no_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> !rvalid_o && !denied_o && !addr_err_o);
  assert_open_no_denial_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(secure_o) |-> !denied_o);
endmodule

// File: tb/tb_key_store_ctrl.sv
module tb_key_store_ctrl;
  localparam int KW = 56;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_i = 0, we_i = 0, lock_i = 0, unlock_i = 0;
  logic [2:0]    addr_i = '0;
  logic [KW-1:0] wdata_i = '0;
  logic [KW-1:0] rdata_o;
  logic          rvalid_o, denied_o, addr_err_o, busy_o, secure_o, cfg_clear_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  key_store_ctrl dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [KW-1:0] pat(int a, int k);
    return (56'h00A5C3_0F1E2D3C ^ (56'(a + 1) * 56'h0011_1111_1111)) + 56'(k * 7919);
  endfunction

  task automatic access(bit w, int a, logic [KW-1:0] d);
    req_i = 1; we_i = w; addr_i = 3'(a); wdata_i = d;
    cyc();
    req_i = 0; we_i = 0;
  endtask

  task automatic idle_flags(string tag);
    cyc();
    chk({tag, " R10 rvalid"}, 64'(rvalid_o), 0);
    chk({tag, " R10 denied"}, 64'(denied_o), 0);
    chk({tag, " R10 addr_err"}, 64'(addr_err_o), 0);
  endtask

  task automatic do_erase(bit poke);
    int n = 0;
    unlock_i = 1; cyc(); unlock_i = 0;
    while (busy_o && n < 20) begin
      n++;
      chk("R5 secure low while busy", 64'(secure_o), 0);
      chk("R5 no early clear", 64'(cfg_clear_o), 0);
      if (n > 1) begin
        chk("R7 rvalid while busy", 64'(rvalid_o), 0);
        chk("R7 addr_err while busy", 64'(addr_err_o), 0);
      end
      if (poke) begin req_i = 1; we_i = (n % 2 == 0); addr_i = 3'(n % 8); wdata_i = pat(n, 99); end
      cyc();
    end
    req_i = 0; we_i = 0;
    chk("R5 busy cycles", 64'(n), 6);
    chk("R5 clear pulse", 64'(cfg_clear_o), 1);
    chk("R7 no resp after busy", 64'(rvalid_o | addr_err_o | denied_o), 0);
    cyc();
    chk("R5 clear single", 64'(cfg_clear_o), 0);
    chk("R5 open after erase", 64'(secure_o), 0);
  endtask

  task automatic sweep_zero(string tag);
    for (int a = 0; a < 6; a++) begin
      access(0, a, '0);
      chk({tag, " R6 rdata zero"}, 64'(rdata_o), 0);
      chk({tag, " R6 rvalid"}, 64'(rvalid_o), 1);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #5 rst_ni = 1'b1;
    cyc();
    chk("R1 secure", 64'(secure_o), 1);
    chk("R1 busy", 64'(busy_o), 0);
    chk("R1 cfg_clear", 64'(cfg_clear_o), 0);
    chk("R1 flags", 64'({rvalid_o, denied_o, addr_err_o}), 0);

    // Locked sweep of all addresses: reads denied or flagged
    for (int a = 0; a < 8; a++) begin
      access(0, a, '0);
      chk("R3/R8 rvalid", 64'(rvalid_o), 1);
      chk("R3 denied", 64'(denied_o), (a < 6) ? 1 : 0);
      chk("R8 addr_err", 64'(addr_err_o), (a < 6) ? 0 : 1);
      chk("R3 rdata zero", 64'(rdata_o), 0);
      idle_flags("locked");
    end
    // Locked writes accepted silently
    for (int a = 0; a < 8; a++) begin
      access(1, a, pat(a, 50));
      chk("R8 write addr_err", 64'(addr_err_o), (a < 6) ? 0 : 1);
      chk("R3 write no rvalid", 64'(rvalid_o), 0);
    end
    // Locked lock request ignored
    lock_i = 1; cyc(); lock_i = 0;
    chk("R9 lock while locked busy", 64'(busy_o), 0);
    chk("R9 lock while locked secure", 64'(secure_o), 1);

    do_erase(1);
    sweep_zero("first erase");

    // Open: several write patterns, back-to-back read after write
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 8; a++) begin
        access(1, a, pat(a, k));
        chk("R8 open write addr_err", 64'(addr_err_o), (a < 6) ? 0 : 1);
        access(0, a, '0);
        chk("R2 read after write", 64'(rdata_o), (a < 6) ? 64'(pat(a, k)) : 0);
        chk("R8 open read addr_err", 64'(addr_err_o), (a < 6) ? 0 : 1);
      end
      for (int a = 0; a < 6; a++) begin
        access(0, a, '0);
        chk("R2 read back sweep", 64'(rdata_o), 64'(pat(a, k)));
        chk("R2 no denial open", 64'(denied_o), 0);
      end
      idle_flags("open");
    end

    // Unlock while open ignored
    unlock_i = 1; cyc(); unlock_i = 0;
    chk("R9 unlock while open busy", 64'(busy_o), 0);
    cyc();
    chk("R9 unlock while open clear", 64'(cfg_clear_o), 0);
    chk("R9 unlock while open secure", 64'(secure_o), 0);
    access(0, 2, '0);
    chk("R9 data kept", 64'(rdata_o), 64'(pat(2, 3)));

    // Lock: next-clock effect, reads denied
    lock_i = 1; cyc(); lock_i = 0;
    chk("R4 secure after lock", 64'(secure_o), 1);
    for (int a = 0; a < 6; a++) begin
      access(0, a, '0);
      chk("R4 denied after lock", 64'(denied_o), 1);
      chk("R4 rdata zero", 64'(rdata_o), 0);
    end

    do_erase(0);
    sweep_zero("second erase");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule